// File: doc/BRIEF.md
# Control-Flow Target Checker

This block sits beside a processor pipeline and enforces coarse control-flow integrity on the stream of retiring instructions. Each instruction arrives with a valid strobe, a flag saying whether it transfers control (jump or taken branch), its program counter and a small tag taken from its code word. A tag marks the word as a legal landing place for a control transfer. The block keeps one bit of state that records "a transfer has just happened". The instruction that executes next must carry the landing-place mark. If it does not, the block reports a violation.

When an instruction breaks the rule, the block holds it back in the same cycle through a combinational stall output. One cycle later it raises a single-cycle interrupt pulse. It also latches the offending program counter. It then stays locked: the stall stays high and no instruction is checked or allowed to change state until software acknowledges the fault. The tags come from static analysis done elsewhere and reach the block already attached to each instruction.

The tag width, the program counter width, the mask of tag bits that mean "legal target" and whether all or any of those bits must be set are all parameters.

Top module: `cfi_target_guard`

## Requirements
- R1: After reset the transfer-pending state is clear, `stall_o` and `viol_o` are low and `fault_pc_o` is zero.
- R2: An instruction that follows a control transfer and whose tag counts as a target is allowed: `stall_o` stays low and no violation is raised.
- R3: An instruction that follows a control transfer and whose tag does not count as a target drives `stall_o` high in its own cycle. `viol_o` is then high for exactly one cycle, starting at the following clock edge.
- R4: `fault_pc_o` takes the program counter of the offending instruction and holds it until an acknowledge.
- R5: After a violation, `stall_o` stays high and instructions are neither checked nor allowed to change state until `ack_i` is seen. From the edge that takes `ack_i`, the stall is released and the transfer-pending state is clear.
- R6: Cycles with `ins_valid_i` low leave the transfer-pending state unchanged.
- R7: A control transfer that lands on a target-tagged word which is itself a control transfer leaves the transfer-pending state set, so the instruction after it is checked too.
- R8: When no transfer is pending, an instruction without the target mark raises no violation.
- R9: With the default parameters, a tag counts as a target when bit 0 is set. The other three tag bits are ignored, so 4'b1011 is a target and 4'b1110 is not.
- R10: `ack_i` while no fault is latched has no effect; a pending transfer stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid_i | input | 1 | An instruction executes this cycle |
| ins_xfer_i | input | 1 | The instruction transfers control |
| ins_tag_i | input | TAG_W | Tag of the instruction's code word |
| ins_pc_i | input | PC_W | Program counter of the instruction |
| ack_i | input | 1 | Software acknowledge of a latched fault |
| stall_o | output | 1 | Blocks the current instruction (combinational) |
| viol_o | output | 1 | One-cycle interrupt pulse after a violation |
| fault_pc_o | output | PC_W | Program counter of the latest offending instruction |

## Verification
The bench targets the cases where the pending bit has to survive or be rebuilt. Bubbles between a transfer and its landing must not clear the bit, or a bad landing would slip through. A transfer landing on a target-tagged transfer must keep the bit set, or the second landing would go unchecked. An acknowledge with no fault latched must not clear it. While the block is locked, a transfer fed in must neither re-fire the pulse nor overwrite the captured program counter. After the acknowledge, a non-target instruction must pass, which shows that the stale pending bit was dropped. A design that got any of these wrong would miss a violation, raise a false one, or lose the faulting address.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
   // How the target mask is applied to an instruction tag
   typedef enum logic {
      MATCH_ALL = 1'b0,
      MATCH_ANY = 1'b1
   } match_e;
endpackage

// File: rtl/cfi_tag_match.sv
module cfi_tag_match #(
   parameter int unsigned        TAG_W       = 4,
   parameter logic [TAG_W-1:0]   TARGET_MASK = 1,
   parameter cfi_pkg::match_e    MATCH       = cfi_pkg::MATCH_ALL
) (
   input  logic [TAG_W-1:0] tag_i,
   output logic             is_tgt_o
);
   localparam logic [TAG_W-1:0] MASK = TARGET_MASK;

   if (TAG_W < 1) begin : g_bad_width
      $error("cfi_tag_match: TAG_W must be at least 1");
   end
   if (TARGET_MASK == '0) begin : g_bad_mask
      $error("cfi_tag_match: TARGET_MASK must select at least one bit");
   end

   logic [TAG_W-1:0] sel;
   assign sel = tag_i & MASK;

   if (MATCH == cfi_pkg::MATCH_ALL) begin : g_all
      assign is_tgt_o = (sel == MASK);
   end else begin : g_any
      assign is_tgt_o = |sel;
   end
endmodule

// File: rtl/cfi_jump_state.sv
module cfi_jump_state (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   input  logic xfer_i,
   input  logic clr_i,
   output logic jump_o
);
   logic jump_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      jump_q <= 1'b0;
      else if (clr_i)  jump_q <= 1'b0;
      else if (step_i) jump_q <= xfer_i;
   end

   assign jump_o = jump_q;

   // R6: no step and no clear keeps the pending bit
   a_r6_hold_on_bubble : assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !clr_i) |=> $stable(jump_q));
   // R7: an accepted transfer always leaves the bit set
   a_r7_xfer_sets : assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && xfer_i && !clr_i) |=> jump_q);
endmodule

// File: rtl/cfi_fault_latch.sv
module cfi_fault_latch #(
   parameter int unsigned PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trip_i,
   input  logic            ack_i,
   input  logic [PC_W-1:0] pc_i,
   output logic            lock_o,
   output logic            pulse_o,
   output logic [PC_W-1:0] pc_o
);
   if (PC_W < 2) begin : g_bad_pc
      $error("cfi_fault_latch: PC_W too small");
   end

   logic            lock_q;
   logic            pulse_q;
   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q  <= 1'b0;
         pulse_q <= 1'b0;
         pc_q    <= '0;
      end else begin
         pulse_q <= trip_i;
         if (lock_q && ack_i) begin
            lock_q <= 1'b0;
         end else if (trip_i) begin
            lock_q <= 1'b1;
            pc_q   <= pc_i;
         end
      end
   end

   assign lock_o  = lock_q;
   assign pulse_o = pulse_q;
   assign pc_o    = pc_q;

   // R3: the interrupt pulse is one cycle wide
   a_r3_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);
   // R5: no new trip while a fault is latched
   a_r5_no_retrip : assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |-> !trip_i);
   // R4: captured address holds until acknowledged
   a_r4_pc_held : assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && !ack_i) |=> (lock_q && $stable(pc_q)));
endmodule

// File: rtl/cfi_target_guard.sv
module cfi_target_guard #(
   parameter int unsigned        PC_W        = 32,
   parameter int unsigned        TAG_W       = 4,
   parameter logic [TAG_W-1:0]   TARGET_MASK = 1,
   parameter cfi_pkg::match_e    MATCH       = cfi_pkg::MATCH_ALL
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_valid_i,
   input  logic             ins_xfer_i,
   input  logic [TAG_W-1:0] ins_tag_i,
   input  logic [PC_W-1:0]  ins_pc_i,
   input  logic             ack_i,
   output logic             stall_o,
   output logic             viol_o,
   output logic [PC_W-1:0]  fault_pc_o
);
   logic is_tgt;
   logic jump_q;
   logic lock_q;
   logic bad;
   logic step;
   logic clr;

   cfi_tag_match #(
      .TAG_W      (TAG_W),
      .TARGET_MASK(TARGET_MASK),
      .MATCH      (MATCH)
   ) u_match (
      .tag_i   (ins_tag_i),
      .is_tgt_o(is_tgt)
   );

   // An instruction is checked only while unlocked
   assign bad  = ins_valid_i && !lock_q && jump_q && !is_tgt;
   assign step = ins_valid_i && !lock_q && !bad;
   assign clr  = ack_i && lock_q;

   cfi_jump_state u_state (
      .clk   (clk),
      .rst_n (rst_n),
      .step_i(step),
      .xfer_i(ins_xfer_i),
      .clr_i (clr),
      .jump_o(jump_q)
   );

   cfi_fault_latch #(.PC_W(PC_W)) u_fault (
      .clk    (clk),
      .rst_n  (rst_n),
      .trip_i (bad),
      .ack_i  (ack_i),
      .pc_i   (ins_pc_i),
      .lock_o (lock_q),
      .pulse_o(viol_o),
      .pc_o   (fault_pc_o)
   );

   assign stall_o = lock_q || bad;

   // R3/R4: a fresh block is followed by the pulse and the captured address
   a_r3_block_then_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o && !lock_q) |=> (viol_o && fault_pc_o == $past(ins_pc_i)));
   // R5: after acknowledge the pending bit is gone
   a_r5_ack_clears : assert property (@(posedge clk) disable iff (!rst_n)
      (lock_q && ack_i) |=> (!jump_q && !lock_q));
   // R8: with nothing pending an instruction is never blocked fresh
   a_r8_idle_no_block : assert property (@(posedge clk) disable iff (!rst_n)
      (!jump_q && !lock_q) |-> !stall_o);
endmodule

// File: tb/tb_cfi_target_guard.sv
module tb_cfi_target_guard;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        ins_valid_i, ins_xfer_i, ack_i;
   logic [3:0]  ins_tag_i;
   logic [31:0] ins_pc_i;
   logic        stall_o, viol_o;
   logic [31:0] fault_pc_o;

   int total = 0;
   int bad   = 0;
   logic st;

   localparam logic [3:0] TGT  = 4'b0001;
   localparam logic [3:0] TGT2 = 4'b1011;
   localparam logic [3:0] NOT  = 4'b1110;

   always #5 clk = ~clk;

   cfi_target_guard dut (
      .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid_i), .ins_xfer_i(ins_xfer_i),
      .ins_tag_i(ins_tag_i), .ins_pc_i(ins_pc_i), .ack_i(ack_i),
      .stall_o(stall_o), .viol_o(viol_o), .fault_pc_o(fault_pc_o)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   // drive one instruction at the falling edge; return the combinational stall
   task automatic issue(input logic x, input logic [3:0] tag, input logic [31:0] pc,
                        output logic s);
      @(negedge clk);
      ins_valid_i = 1'b1; ins_xfer_i = x; ins_tag_i = tag; ins_pc_i = pc; ack_i = 1'b0;
      #1 s = stall_o;
   endtask

   task automatic idle();
      @(negedge clk);
      ins_valid_i = 1'b0; ins_xfer_i = 1'b0; ins_tag_i = '0; ack_i = 1'b0;
      #1;
   endtask

   task automatic do_ack(input string req);
      @(negedge clk);
      ins_valid_i = 1'b0; ack_i = 1'b1;
      #1 chk({req, " stall during ack"}, {31'd0, stall_o}, 32'd1);
      @(negedge clk);
      ack_i = 1'b0;
      #1 chk({req, " stall released"}, {31'd0, stall_o}, 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 stall", {31'd0, stall_o}, 32'd0);
      chk("R1 viol", {31'd0, viol_o}, 32'd0);
      chk("R1 fault_pc", fault_pc_o, 32'd0);
      issue(1'b0, NOT, 32'h10, st);
      chk("R1 no pending after reset", {31'd0, st}, 32'd0);
   endtask

   task automatic t_legal_landing();
      issue(1'b1, 4'b0000, 32'h100, st);
      chk("R2 transfer itself", {31'd0, st}, 32'd0);
      issue(1'b0, TGT, 32'h200, st);
      chk("R2 target landing", {31'd0, st}, 32'd0);
      issue(1'b1, 4'b0000, 32'h204, st);
      issue(1'b0, TGT2, 32'h280, st);
      chk("R9 multi-bit tag is target", {31'd0, st}, 32'd0);
      issue(1'b0, 4'b0000, 32'h284, st);
      chk("R8 plain after landing", {31'd0, st}, 32'd0);
      idle();
      chk("R2 no pulse", {31'd0, viol_o}, 32'd0);
   endtask

   task automatic t_bad_landing();
      issue(1'b1, TGT, 32'h300, st);
      issue(1'b0, NOT, 32'h344, st);
      chk("R3 stall same cycle", {31'd0, st}, 32'd1);
      idle();
      chk("R3 pulse", {31'd0, viol_o}, 32'd1);
      chk("R4 fault pc", fault_pc_o, 32'h344);
      idle();
      chk("R3 pulse one cycle", {31'd0, viol_o}, 32'd0);
   endtask

   task automatic t_locked();
      issue(1'b1, 4'b0000, 32'h400, st);
      chk("R5 blocked while locked", {31'd0, st}, 32'd1);
      idle();
      chk("R5 no new pulse", {31'd0, viol_o}, 32'd0);
      chk("R4 pc held", fault_pc_o, 32'h344);
      do_ack("R5");
      issue(1'b0, NOT, 32'h500, st);
      chk("R5 pending cleared by ack", {31'd0, st}, 32'd0);
      idle();
      chk("R5 no pulse after ack", {31'd0, viol_o}, 32'd0);
   endtask

   task automatic t_bubbles();
      issue(1'b1, 4'b0000, 32'h5f0, st);
      idle(); idle(); idle();
      issue(1'b0, NOT, 32'h600, st);
      chk("R6 bubbles keep pending", {31'd0, st}, 32'd1);
      idle();
      chk("R6 fault pc", fault_pc_o, 32'h600);
      do_ack("R6");
   endtask

   task automatic t_chain();
      issue(1'b1, 4'b0000, 32'h700, st);
      issue(1'b1, TGT, 32'h800, st);
      chk("R7 chained landing allowed", {31'd0, st}, 32'd0);
      issue(1'b0, TGT, 32'h880, st);
      chk("R7 second landing ok", {31'd0, st}, 32'd0);
      issue(1'b1, 4'b0000, 32'h884, st);
      issue(1'b1, TGT, 32'h8c0, st);
      issue(1'b0, NOT, 32'h900, st);
      chk("R7 second landing checked", {31'd0, st}, 32'd1);
      idle();
      chk("R7 fault pc", fault_pc_o, 32'h900);
      do_ack("R7");
   endtask

   task automatic t_ack_ignored();
      issue(1'b1, 4'b0000, 32'h9f0, st);
      @(negedge clk);
      ins_valid_i = 1'b0; ack_i = 1'b1;
      #1 chk("R10 no stall on stray ack", {31'd0, stall_o}, 32'd0);
      issue(1'b0, NOT, 32'hA00, st);
      chk("R10 pending survives ack", {31'd0, st}, 32'd1);
      idle();
      chk("R10 pulse", {31'd0, viol_o}, 32'd1);
      chk("R10 fault pc", fault_pc_o, 32'hA00);
      do_ack("R10");
   endtask

   task automatic t_plain();
      for (int i = 0; i < 4; i++) begin
         issue(1'b0, NOT, 32'hB00 + 32'(i * 4), st);
         chk("R8 plain non-target", {31'd0, st}, 32'd0);
      end
      idle();
      chk("R8 no pulse", {31'd0, viol_o}, 32'd0);
      chk("R8 fault pc unchanged", fault_pc_o, 32'hA00);
   endtask

   initial begin
      #2000000;
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ins_valid_i = 1'b0; ins_xfer_i = 1'b0; ins_tag_i = '0;
      ins_pc_i = '0; ack_i = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      #1;
      t_reset();
      t_legal_landing();
      t_bad_landing();
      t_locked();
      t_bubbles();
      t_chain();
      t_ack_ignored();
      t_plain();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule